// File: doc/BRIEF.md
# Gated DC-Restore Clamp Controller

This block closes the digital half of a DC-restore loop for two video channels. The input coupling capacitor of each channel sits ahead of its 8-bit converter. During the clamp window that an external gate signal marks, the block compares each channel's converter output code with a programmed black level. From that comparison it commands the channel's current source either to charge the capacitor, which raises the input, or to discharge it, which lowers the input. Repeated over many lines, this pulls the clamped portion of the video onto the chosen code.

Each channel takes a 2-bit level select from the control block as a static input. The two channels decode that select through different tables. Channel A offers 16, 24, 64 and 128. Channel B offers only 16, 64 and 128, and it treats both encodings that have a low upper bit as 128. The gate arrives from another clock domain and is resynchronised before use. Both enables are registered. A status output shows, per channel, the level that governed the most recent decision.

Top module: `dc_clamp_ctrl`

## Requirements
- R1: Channel A level from sel_a_i {bit1,bit0}: 2'b00 gives 16, 2'b10 gives 24, 2'b01 gives 64, 2'b11 gives 128.
- R2: Channel B level from sel_b_i {bit1,bit0}: 2'b10 gives 16, 2'b11 gives 64, 2'b00 and 2'b01 both give 128. Channel B never selects 24.
- R3: While the synchronised gate is low, every charge and discharge enable is 0.
- R4: While the synchronised gate is high, a code strictly above the channel's level sets that channel's discharge enable at the next rising clock edge.
- R5: While the synchronised gate is high, a code at or below the level, equality included, sets that channel's charge enable at the next rising clock edge.
- R6: A channel's charge and discharge enables are never both 1.
- R7: gate_i passes through a two-flop synchroniser. A change of gate_i in place before rising edge k first affects the enables at edge k+2, so the enables show it after the third edge.
- R8: While rst_ni is low, all enables are 0, lvl_a_o is 16 and lvl_b_o is 128.
- R9: lvl_a_o and lvl_b_o show, one edge later, the level that the select in place before that edge decodes to. This is the same level the enables updated at that edge were computed against.
- R10: The two channels are independent. Each channel's enables depend only on its own code and its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Clamp window, asynchronous to clk_i |
| code_a_i | input | 8 | Channel A latched converter output |
| code_b_i | input | 8 | Channel B latched converter output |
| sel_a_i | input | 2 | Channel A level select |
| sel_b_i | input | 2 | Channel B level select |
| chg_a_o | output | 1 | Channel A charge (source) enable |
| dis_a_o | output | 1 | Channel A discharge (sink) enable |
| chg_b_o | output | 1 | Channel B charge (source) enable |
| dis_b_o | output | 1 | Channel B discharge (sink) enable |
| lvl_a_o | output | 8 | Channel A active level |
| lvl_b_o | output | 8 | Channel B active level |

## Verification
The embedded assertions watch five things on every cycle: exclusivity of the enables, silence outside the synchronised window, the above-or-not decision one edge after each compare, the synchroniser's two-edge delay on a rising gate, and the absence of level 24 on channel B. Some properties only the bench scenarios can demonstrate. These are the full decode tables including channel B's don't-care encodings, the equality boundary, the exact edge at which the enables turn off after the gate falls, the reset values of the status, and convergence of a modelled capacitor onto different levels on the two channels at once.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_CH   = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam code_t LVL_16  = code_t'(16);
  localparam code_t LVL_24  = code_t'(24);
  localparam code_t LVL_64  = code_t'(64);
  localparam code_t LVL_128 = code_t'(128);

  function automatic code_t decode_full(sel_t s);
    case (s)
      2'b00:   return LVL_16;
      2'b10:   return LVL_24;
      2'b01:   return LVL_64;
      default: return LVL_128;
    endcase
  endfunction

  // reduced table: upper bit low is don't-care on bit 0
  function automatic code_t decode_reduced(sel_t s);
    case (s)
      2'b10:   return LVL_16;
      2'b11:   return LVL_64;
      default: return LVL_128;
    endcase
  endfunction
endpackage

// File: rtl/clamp_gate_sync.sv
module clamp_gate_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic gate_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= gate_i;
      sync_q <= meta_q;
    end
  end

  assign gate_o = sync_q;

  a_r7_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(gate_i, 2));
endmodule

// File: rtl/clamp_level_sel.sv
module clamp_level_sel
  import clamp_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  sel_t  sel_i,
  output code_t level_o,
  output code_t status_o
);
  localparam sel_t SEL_RST = '0;
  code_t lvl_d, lvl_q;

  generate
    if (REDUCED) begin : g_reduced
      assign lvl_d = decode_reduced(sel_i);
      always_comb begin
        a_r2_no_24: assert (lvl_d != LVL_24);
      end
    end else begin : g_full
      assign lvl_d = decode_full(sel_i);
    end
  endgenerate

  localparam code_t LVL_RST = REDUCED ? decode_reduced(SEL_RST) : decode_full(SEL_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= LVL_RST;
    else         lvl_q <= lvl_d;
  end

  assign level_o  = lvl_d;
  assign status_o = lvl_q;
endmodule

// File: rtl/clamp_decide.sv
module clamp_decide
  import clamp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  gate_i,
  input  code_t code_i,
  input  code_t level_i,
  output logic  chg_o,
  output logic  dis_o
);
  logic above;
  logic chg_q, dis_q;

  assign above = code_i > level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      chg_q <= gate_i & ~above;
      dis_q <= gate_i &  above;
    end
  end

  assign chg_o = chg_q;
  assign dis_o = dis_q;

  a_r3_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> !chg_q && !dis_q);
  a_r4_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && code_i > level_i) |=> dis_q);
  a_r5_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && code_i <= level_i) |=> chg_q);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chg_q && dis_q));
endmodule

// File: rtl/dc_clamp_ctrl.sv
module dc_clamp_ctrl
  import clamp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gate_i,
  input  logic [7:0] code_a_i,
  input  logic [7:0] code_b_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       chg_a_o,
  output logic       dis_a_o,
  output logic       chg_b_o,
  output logic       dis_b_o,
  output logic [7:0] lvl_a_o,
  output logic [7:0] lvl_b_o
);
  logic  gate_s;
  code_t code  [N_CH];
  sel_t  sel   [N_CH];
  code_t level [N_CH];
  code_t stat  [N_CH];
  logic  chg   [N_CH];
  logic  dis   [N_CH];

  assign code[0] = code_a_i;
  assign code[1] = code_b_i;
  assign sel[0]  = sel_a_i;
  assign sel[1]  = sel_b_i;

  clamp_gate_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .gate_o (gate_s)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    clamp_level_sel #(.REDUCED(g == 1)) u_lvl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel[g]),
      .level_o  (level[g]),
      .status_o (stat[g])
    );
    clamp_decide u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gate_i  (gate_s),
      .code_i  (code[g]),
      .level_i (level[g]),
      .chg_o   (chg[g]),
      .dis_o   (dis[g])
    );
  end

  assign chg_a_o = chg[0];
  assign dis_a_o = dis[0];
  assign chg_b_o = chg[1];
  assign dis_b_o = dis[1];
  assign lvl_a_o = stat[0];
  assign lvl_b_o = stat[1];
endmodule

// File: tb/dc_clamp_ctrl_test.sv
module dc_clamp_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b0;
  logic [7:0] code_a = '0, code_b = '0;
  logic [1:0] sel_a = '0, sel_b = '0;
  logic chg_a, dis_a, chg_b, dis_b;
  logic [7:0] lvl_a, lvl_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dc_clamp_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate),
    .code_a_i(code_a), .code_b_i(code_b), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .chg_a_o(chg_a), .dis_a_o(dis_a), .chg_b_o(chg_b), .dis_b_o(dis_b),
    .lvl_a_o(lvl_a), .lvl_b_o(lvl_b)
  );

  function automatic logic [7:0] ref_a(logic [1:0] s);
    case (s) 2'b00: return 8'd16; 2'b10: return 8'd24; 2'b01: return 8'd64; default: return 8'd128; endcase
  endfunction
  function automatic logic [7:0] ref_b(logic [1:0] s);
    case (s) 2'b10: return 8'd16; 2'b11: return 8'd64; default: return 8'd128; endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // at negedge: drive, let one edge pass, check at next negedge; gate assumed settled
  task automatic step(logic [7:0] ca, logic [7:0] cb, logic [1:0] sa, logic [1:0] sb, bit on);
    logic [1:0] ea, eb;
    code_a = ca; code_b = cb; sel_a = sa; sel_b = sb;
    @(posedge clk); @(negedge clk);
    ea = on ? ((ca > ref_a(sa)) ? 2'b01 : 2'b10) : 2'b00;
    eb = on ? ((cb > ref_b(sb)) ? 2'b01 : 2'b10) : 2'b00;
    check({chg_a, dis_a} == ea, on ? "R4/R5 chan A" : "R3 chan A", {chg_a, dis_a}, ea);
    check({chg_b, dis_b} == eb, on ? "R4/R5/R10 chan B" : "R3 chan B", {chg_b, dis_b}, eb);
    check(!(chg_a && dis_a) && !(chg_b && dis_b), "R6 exclusive", {chg_a, dis_a, chg_b, dis_b}, 0);
    check(lvl_a == ref_a(sa), "R1/R9 level A", lvl_a, ref_a(sa));
    check(lvl_b == ref_b(sb), "R2/R9 level B", lvl_b, ref_b(sb));
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int ma, mb;
    seed = 32'd4711;
    void'($urandom(seed));
    sel_a = 2'b11; sel_b = 2'b10;
    #35;
    // R8 reset state, regardless of selects
    check(lvl_a == 8'd16, "R8 reset lvl A", lvl_a, 16);
    check(lvl_b == 8'd128, "R8 reset lvl B", lvl_b, 128);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b0, "R8 reset enables", {chg_a, dis_a, chg_b, dis_b}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 full tables, gate low (R3)
    for (int s = 0; s < 4; s++) step(8'd255, 8'd0, 2'(s), 2'(s), 0);
    for (int i = 0; i < 20; i++) step(8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom), 0);

    // R7 gate rise latency
    code_a = 8'd200; code_b = 8'd0; sel_a = 2'b00; sel_b = 2'b00;
    gate = 1'b1;
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b0, "R7 rise edge1", {chg_a, dis_a, chg_b, dis_b}, 0);
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b0, "R7 rise edge2", {chg_a, dis_a, chg_b, dis_b}, 0);
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b0110, "R7 rise edge3", {chg_a, dis_a, chg_b, dis_b}, 4'b0110);

    // random with gate high
    for (int i = 0; i < 300; i++) step(8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom), 1);

    // equality and +1 boundaries per select
    for (int s = 0; s < 4; s++) begin
      step(ref_a(2'(s)), ref_b(2'(s)), 2'(s), 2'(s), 1);           // R5 equal -> charge
      step(ref_a(2'(s)) + 8'd1, ref_b(2'(s)) + 8'd1, 2'(s), 2'(s), 1); // R4 one above -> discharge
      step(ref_a(2'(s)) - 8'd1, 8'd255, 2'(s), 2'(s), 1);
    end

    // R7 gate fall latency
    code_a = 8'd0; code_b = 8'd255; sel_a = 2'b01; sel_b = 2'b11;
    @(posedge clk); @(negedge clk);
    gate = 1'b0;
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b1001, "R7 fall edge1", {chg_a, dis_a, chg_b, dis_b}, 4'b1001);
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b1001, "R7 fall edge2", {chg_a, dis_a, chg_b, dis_b}, 4'b1001);
    @(posedge clk); @(negedge clk);
    check({chg_a, dis_a, chg_b, dis_b} == 4'b0, "R7 fall edge3", {chg_a, dis_a, chg_b, dis_b}, 0);

    // integrator loop: A to 24, B to 64 from opposite ends (R10)
    ma = 250; mb = 3;
    sel_a = 2'b10; sel_b = 2'b11; gate = 1'b1;
    for (int i = 0; i < 600; i++) begin
      code_a = 8'(ma); code_b = 8'(mb);
      @(posedge clk); @(negedge clk);
      if (chg_a) ma = ma + 1; else if (dis_a) ma = ma - 1;
      if (chg_b) mb = mb + 1; else if (dis_b) mb = mb - 1;
    end
    check(ma >= 23 && ma <= 26, "R4/R5 loop A settles near 24", ma, 24);
    check(mb >= 63 && mb <= 66, "R4/R5/R10 loop B settles near 64", mb, 64);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule